// File: doc/BRIEF.md
# Eight-Channel Load Fault Qualifier

This block watches the raw fault indications coming from the analog side of eight low-side output channels and turns them into a stable diagnostic picture. Each channel presents four raw flags: current limit reached, thermal shutdown active, drain below the open-load threshold, and sink current sensed for a short to ground. Which of these is meaningful depends on whether the channel is commanded on or off. Overcurrent and thermal flags count only while the channel is on. Open-load and ground-short flags count only while it is off.

A flag that is eligible in the channel's present state must stay true for a programmable number of clock cycles before it is accepted. An accepted fault stores a 2-bit code per channel. A later accepted fault replaces the stored code. A return to normal leaves the stored code in place. A single active-low output reports that any channel holds an error. The serial interface issues a one-cycle clear pulse on its chip-select rising edge, which empties every channel's store. It issues a one-cycle capture pulse at the chip-select falling edge, which freezes a copy of all codes for shifting out.

Top module: `chan_fault_monitor`

## Requirements
- R1: After reset, `fault_n` is 1 and `snap_codes` reads all ones (every channel 2'b11, normal).
- R2: An eligible raw flag is accepted at the FAULT_DELAY-th consecutive rising clock edge at which it is sampled true. A flag that is true for fewer consecutive edges and then drops stores nothing.
- R3: While a channel is on, `ilim_hit` or `therm_off` stores code 2'b10. While the channel is off, these flags are ignored and the channel keeps reporting 2'b11.
- R4: While a channel is off, `ol_low` stores code 2'b01. While it is on, this flag is ignored.
- R5: While a channel is off, `scg_sense` stores code 2'b00. This flag is ignored while the channel is on. When ground short and open load are accepted in the same cycle, 2'b00 wins.
- R6: `fault_n` goes low in the cycle that follows the edge at which any channel stores an error. It stays low while any error is stored.
- R7: A newly accepted error replaces the channel's stored code. The disappearance of a condition never returns a stored code to 2'b11.
- R8: A `cs_rise` pulse returns every stored code to 2'b11 and sets `fault_n` to 1 for the following cycle. A condition that is still held is stored again one edge later.
- R9: `snap_codes` loads the stored codes on a `snap_load` pulse and otherwise holds. An error stored after the capture appears only at the next capture, even if its condition has since gone.
- R10: Channel i occupies bits [2i+1:2i] of `snap_codes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_on | input | NCH | Commanded on state per channel |
| ilim_hit | input | NCH | Raw current-limit flag per channel |
| therm_off | input | NCH | Raw thermal shutdown flag per channel |
| ol_low | input | NCH | Raw drain-below-open-load-threshold flag per channel |
| scg_sense | input | NCH | Raw ground-short sink current flag per channel |
| cs_rise | input | 1 | One-cycle clear pulse at chip-select rising edge |
| snap_load | input | 1 | One-cycle capture pulse at chip-select falling edge |
| snap_codes | output | 2*NCH | Captured 2-bit codes, channel i at [2i+1:2i] |
| fault_n | output | 1 | Active-low, any channel holds an error |

## Verification
The bench drives a flag for exactly one cycle fewer than the delay. A filter that is off by one would latch this glitch and pull `fault_n` low. It also drives flags that are ineligible in the channel's present state, such as overcurrent on an off channel or open load on an on channel, which a design that ignored the state would store. Further cases cover simultaneous ground short and open load, which catches a reversed priority, and a clear while a fault persists, which must show one cycle of `fault_n` high followed by re-latching. A capture-then-fault sequence shows that a design with a transparent snapshot would leak the new error into the current frame. Long random runs with slowly toggling flags compare every cycle against a reference model in the bench.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

    typedef enum logic [1:0] {
        DC_GND_SHORT = 2'b00,
        DC_OPEN      = 2'b01,
        DC_OVER      = 2'b10,
        DC_NORMAL    = 2'b11
    } diag_code_t;

    localparam int N_CLASS = 3;
    localparam int CL_OVER = 0;
    localparam int CL_OPEN = 1;
    localparam int CL_GND  = 2;

    typedef logic [N_CLASS-1:0] class_vec_t;

    // ground short outranks open load, which outranks overcurrent
    function automatic diag_code_t resolve_code(class_vec_t q);
        diag_code_t c;
        if (q[CL_GND])       c = DC_GND_SHORT;
        else if (q[CL_OPEN]) c = DC_OPEN;
        else if (q[CL_OVER]) c = DC_OVER;
        else                 c = DC_NORMAL;
        return c;
    endfunction

    function automatic class_vec_t eligible(logic on, logic ilim, logic therm,
                                            logic ol, logic scg);
        class_vec_t v;
        v[CL_OVER] = on & (ilim | therm);
        v[CL_OPEN] = ~on & ol;
        v[CL_GND]  = ~on & scg;
        return v;
    endfunction

endpackage

// File: rtl/fault_persist.sv
module fault_persist #(
    parameter int FAULT_DELAY = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic qual
);
    localparam int CW = (FAULT_DELAY > 2) ? $clog2(FAULT_DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(FAULT_DELAY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = cond && (cnt == LAST);
endmodule

// File: rtl/chan_diag.sv
module chan_diag
    import fdiag_pkg::*;
#(
    parameter int FAULT_DELAY = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       on,
    input  logic       ilim,
    input  logic       therm,
    input  logic       ol,
    input  logic       scg,
    input  logic       clr,
    output diag_code_t code,
    output logic       err
);
    class_vec_t cond;
    class_vec_t qual;

    assign cond = eligible(on, ilim, therm, ol, scg);

    for (genvar k = 0; k < N_CLASS; k++) begin : g_filt
        fault_persist #(.FAULT_DELAY(FAULT_DELAY)) i_filt (
            .clk (clk),
            .rst (rst),
            .cond(cond[k]),
            .qual(qual[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code <= DC_NORMAL;
            err  <= 1'b0;
        end else if (|qual) begin
            code <= resolve_code(qual);
            err  <= 1'b1;
        end
    end
endmodule

// File: rtl/diag_snapshot.sv
module diag_snapshot #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] live,
    output logic [WIDTH-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= '1;
        else if (load) held <= live;
    end
endmodule

// File: rtl/chan_fault_monitor.sv
module chan_fault_monitor
    import fdiag_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int FAULT_DELAY = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   chan_on,
    input  logic [NCH-1:0]   ilim_hit,
    input  logic [NCH-1:0]   therm_off,
    input  logic [NCH-1:0]   ol_low,
    input  logic [NCH-1:0]   scg_sense,
    input  logic             cs_rise,
    input  logic             snap_load,
    output logic [2*NCH-1:0] snap_codes,
    output logic             fault_n
);
    localparam int CODE_W = 2 * NCH;

    logic [CODE_W-1:0] live_codes;
    logic [NCH-1:0]    err_vec;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        diag_code_t c;
        chan_diag #(.FAULT_DELAY(FAULT_DELAY)) i_ch (
            .clk  (clk),
            .rst  (rst),
            .on   (chan_on[i]),
            .ilim (ilim_hit[i]),
            .therm(therm_off[i]),
            .ol   (ol_low[i]),
            .scg  (scg_sense[i]),
            .clr  (cs_rise),
            .code (c),
            .err  (err_vec[i])
        );
        assign live_codes[2*i +: 2] = c;
    end

    diag_snapshot #(.WIDTH(CODE_W)) i_snap (
        .clk (clk),
        .rst (rst),
        .load(snap_load),
        .live(live_codes),
        .held(snap_codes)
    );

    assign fault_n = ~|err_vec;
endmodule

// File: rtl/chan_fault_monitor_chk.sv
module chan_fault_monitor_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   chan_on,
    input logic [NCH-1:0]   ilim_hit,
    input logic [NCH-1:0]   therm_off,
    input logic [NCH-1:0]   ol_low,
    input logic [NCH-1:0]   scg_sense,
    input logic             cs_rise,
    input logic             snap_load,
    input logic [2*NCH-1:0] snap_codes,
    input logic             fault_n
);
    logic [NCH-1:0] any_elig;
    assign any_elig = (chan_on & (ilim_hit | therm_off)) | (~chan_on & (ol_low | scg_sense));

    // R8: clear pulse leaves the fault output released for the next cycle
    p_clear_release_r8: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> fault_n);

    // R9: captured codes change only on a capture pulse
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !snap_load |=> $stable(snap_codes));

    // R6: the fault output falls only when some eligible flag was present
    p_fall_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> $past(|any_elig));

    // R2: with no eligible flag anywhere, nothing new can be stored
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        (fault_n && !(|any_elig)) |=> fault_n);

    // R1: out of reset the capture register is all normal
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (snap_codes == '1 && fault_n));
endmodule

bind chan_fault_monitor chan_fault_monitor_chk #(.NCH(NCH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_on   (chan_on),
    .ilim_hit  (ilim_hit),
    .therm_off (therm_off),
    .ol_low    (ol_low),
    .scg_sense (scg_sense),
    .cs_rise   (cs_rise),
    .snap_load (snap_load),
    .snap_codes(snap_codes),
    .fault_n   (fault_n)
);

// File: tb/test_chan_fault_monitor.sv
module test_chan_fault_monitor;
    localparam int NCH = 8;
    localparam int D   = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH-1:0]   chan_on = '0, ilim_hit = '0, therm_off = '0, ol_low = '0, scg_sense = '0;
    logic             cs_rise = 1'b0, snap_load = 1'b0;
    logic [2*NCH-1:0] snap_codes;
    logic             fault_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    chan_fault_monitor #(.NCH(NCH), .FAULT_DELAY(D)) i_chan_fault_monitor (
        .clk(clk), .rst(rst), .chan_on(chan_on), .ilim_hit(ilim_hit),
        .therm_off(therm_off), .ol_low(ol_low), .scg_sense(scg_sense),
        .cs_rise(cs_rise), .snap_load(snap_load),
        .snap_codes(snap_codes), .fault_n(fault_n)
    );

    // reference model built from the requirements
    int              m_cnt [NCH][3];
    logic [1:0]      m_code[NCH];
    logic            m_err [NCH];
    logic [2*NCH-1:0] m_snap;

    function automatic logic m_fault_n();
        logic e = 1'b0;
        for (int i = 0; i < NCH; i++) e |= m_err[i];
        return ~e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_code[i] = 2'b11; m_err[i] = 1'b0;
                for (int k = 0; k < 3; k++) m_cnt[i][k] = 0;
            end
            m_snap = '1;
        end else begin
            if (snap_load)
                for (int i = 0; i < NCH; i++) m_snap[2*i +: 2] = m_code[i];
            for (int i = 0; i < NCH; i++) begin
                logic [2:0] c, q;
                c[0] = chan_on[i] & (ilim_hit[i] | therm_off[i]);
                c[1] = ~chan_on[i] & ol_low[i];
                c[2] = ~chan_on[i] & scg_sense[i];
                for (int k = 0; k < 3; k++) begin
                    q[k] = c[k] && (m_cnt[i][k] + 1 >= D);
                    m_cnt[i][k] = c[k] ? ((m_cnt[i][k] + 1 >= D) ? D - 1 : m_cnt[i][k] + 1) : 0;
                end
                if (cs_rise) begin m_code[i] = 2'b11; m_err[i] = 1'b0; end
                else if (q[2]) begin m_code[i] = 2'b00; m_err[i] = 1'b1; end
                else if (q[1]) begin m_code[i] = 2'b01; m_err[i] = 1'b1; end
                else if (q[0]) begin m_code[i] = 2'b10; m_err[i] = 1'b1; end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        cs_rise = 1'b1; cyc(1); cs_rise = 1'b0;
    endtask

    task automatic capture();
        snap_load = 1'b1; cyc(1); snap_load = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3); rst = 1'b0; cyc(1);
        check("R1 fault_n", fault_n, 1);
        check("R1 snap", snap_codes, 16'hFFFF);

        // R2/R3/R6: overcurrent on channel 2 while on
        chan_on[2] = 1; ilim_hit[2] = 1;
        cyc(D - 1); check("R2 not yet", fault_n, 1);
        cyc(1);     check("R6 fault low", fault_n, 0);
        capture();  check("R3 R10 code 10 ch2", snap_codes, 16'hFFEF);

        // R8: clear while held, then relatch
        pulse_clear(); check("R8 released", fault_n, 1);
        cyc(1);        check("R8 relatched", fault_n, 0);
        ilim_hit[2] = 0; cyc(1); pulse_clear(); cyc(2);
        check("R8 cleared", fault_n, 1);
        capture(); check("R8 snap normal", snap_codes, 16'hFFFF);

        // R2: glitch shorter than delay (thermal flag)
        therm_off[2] = 1; cyc(D - 1); therm_off[2] = 0; cyc(D + 2);
        check("R2 glitch ignored", fault_n, 1);

        // R3: overcurrent on an off channel is ignored
        chan_on[2] = 0; ilim_hit[2] = 1; cyc(D + 3);
        check("R3 off ignored", fault_n, 1);
        ilim_hit[2] = 0; capture(); check("R3 off code", snap_codes, 16'hFFFF);

        // R4/R7: open load on off channel 5, then gone
        ol_low[5] = 1; cyc(D); check("R4 latched", fault_n, 0);
        ol_low[5] = 0; cyc(4);
        check("R7 normal keeps error", fault_n, 0);
        capture(); check("R4 code 01 ch5", snap_codes, 16'hF7FF);
        pulse_clear();

        // R4: open load on an on channel is ignored
        chan_on[5] = 1; ol_low[5] = 1; cyc(D + 3);
        check("R4 on ignored", fault_n, 1);
        ol_low[5] = 0; chan_on[5] = 0; cyc(1);

        // R5: ground short beats open load
        scg_sense[1] = 1; ol_low[1] = 1; cyc(D);
        scg_sense[1] = 0; ol_low[1] = 0;
        capture(); check("R5 priority 00", snap_codes, 16'hFFF3);
        // R7: newer overcurrent replaces it
        chan_on[1] = 1; ilim_hit[1] = 1; cyc(D);
        ilim_hit[1] = 0; cyc(1);
        capture(); check("R7 overwrite 10", snap_codes, 16'hFFFB);
        // R5: ground short ignored while on
        scg_sense[1] = 1; cyc(D + 2); scg_sense[1] = 0;
        capture(); check("R5 on ignored", snap_codes, 16'hFFFB);
        chan_on[1] = 0; pulse_clear(); cyc(1);

        // R9: error after capture waits for next frame
        capture(); check("R9 frame clean", snap_codes, 16'hFFFF);
        ol_low[7] = 1; cyc(D); ol_low[7] = 0; cyc(3);
        check("R9 held", snap_codes, 16'hFFFF);
        check("R6 low", fault_n, 0);
        capture(); check("R9 next frame", snap_codes, 16'h7FFF);
        pulse_clear(); cyc(2);

        // random phase against model
        for (int t = 0; t < 4000; t++) begin
            for (int i = 0; i < NCH; i++) begin
                if ($urandom_range(0, 40) == 0) chan_on[i]   = ~chan_on[i];
                if ($urandom_range(0, 9)  == 0) ilim_hit[i]  = ~ilim_hit[i];
                if ($urandom_range(0, 15) == 0) therm_off[i] = ~therm_off[i];
                if ($urandom_range(0, 9)  == 0) ol_low[i]    = ~ol_low[i];
                if ($urandom_range(0, 12) == 0) scg_sense[i] = ~scg_sense[i];
            end
            cs_rise   = ($urandom_range(0, 30) == 0);
            snap_load = ($urandom_range(0, 15) == 0);
            cyc(1);
            check("R6 random fault_n", fault_n, m_fault_n());
            check("R9 random snap", snap_codes, m_snap);
        end
        finish_run();
    end
endmodule